// File: doc/BRIEF.md
# CAN Timestamp Timer with Interrupt Flags

This block provides the time base that a CAN controller uses to stamp frames. A 16-bit up-counter advances on each cycle in which the tick enable is high. When it passes its all-ones value, it does not fall back to zero. Instead it reloads from a programmable offset register and records an overrun. A neighbouring compare channel can also force the counter to a chosen value through a force-load request. Forcing the all-ones value records an overrun as well.

A compare register raises a compare-match event in one of two modes. In the first mode it matches against the raw count. In the second mode it matches against an external cycle count added to the counter's upper twelve bits. A compare value of zero disables matching. A wake-up detector watches the CAN receive line, which is recessive when high and dominant when low. The line passes through a two-flop synchronizer. While the controller sleeps, a recessive-to-dominant edge records a wake-up event. When the auto-wake control bit is set, the same edge also produces a one-cycle wake request.

The three events go into sticky flags. Software reads the flags and clears them by writing ones through a small register port. Each flag has its own enable bit, and a single interrupt line is the OR of all flags that are both set and enabled.

Top module: `can_stamp_timer`

## Requirements
- R1: After reset, every register reads 0, irq and wakeReq are 0, and with tickEn high the counter increments by one per clock.
- R2: When tickEn is high and the counter holds 0xFFFF, the next value is the offset register (address 1), not zero, and the overrun flag (flag bit 0) is set.
- R3: A forceLoad pulse loads forceValue into the counter; the overrun flag is set if and only if forceValue is 0xFFFF.
- R4: A write to the flag register (address 4) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R5: If a flag's event and a clear of that flag occur in the same cycle, the flag ends set.
- R6: With compare mode 0 (control register address 3, bit 0), the compare flag (flag bit 2) is set on the clock after the counter first equals the compare register (address 2); it is not set again while that equality persists.
- R7: With compare mode 1, the compare target is cycleCount plus counter bits [15:4], zero-extended to 16 bits.
- R8: The compare flag is never set while the compare register holds 0x0000.
- R9: A high-to-low transition on rxd while sleepMode is high sets the wake flag (flag bit 1) on the third rising edge after rxd falls; the same transition while awake sets nothing.
- R10: When autoWake is high, wakeReq pulses high for one cycle, aligned with the wake flag being set.
- R11: irq is high exactly when some flag is set and its enable bit (control bits 8, 9 and 10 for flag bits 0, 1 and 2) is set.
- R12: Register reads return the counter (address 0), offset (1), compare (2), control (3) and flags (4) combinationally on rdData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable |
| forceLoad | input | 1 | Force counter to forceValue |
| forceValue | input | 16 | Value for forced load |
| cycleCount | input | 4 | Cycle count used in compare mode 1 |
| rxd | input | 1 | CAN receive line (1 = recessive) |
| sleepMode | input | 1 | Controller is sleeping |
| autoWake | input | 1 | Auto-wake control bit |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data |
| irq | output | 1 | Combined interrupt request |
| wakeReq | output | 1 | One-cycle wake request |

## Verification
The assertions assume that rxd, sleepMode and the register strobes change only between clock edges, and that forceLoad and a counter write never coincide with an expectation about the tick path. The overrun property is therefore qualified to cycles with no force and no counter write. The bench drives every input on the falling edge and holds it for a whole cycle. It raises tickEn only for counted windows, so every counter value at a check is known exactly. Each scenario clears all flags first, so that no event left over from an earlier scenario is attributed to the one under test.

// File: rtl/can_stamp_pkg.sv
package can_stamp_pkg;
  localparam int TS_W    = 16;
  localparam int ADDR_W  = 3;
  localparam int N_FLAGS = 3;

  localparam logic [ADDR_W-1:0] A_CNT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_OFF  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

  localparam int F_OVF  = 0;
  localparam int F_WAKE = 1;
  localparam int F_CMP  = 2;

  localparam int IE_LSB = 8;

  typedef struct packed {
    logic            cntWr;
    logic            offWr;
    logic            cmpWr;
    logic            cmpMode;
    logic [TS_W-1:0] wrData;
  } ctlStrobe_t;

  typedef struct packed {
    logic ovfEv;
    logic wakeEv;
    logic cmpEv;
  } evtStrobe_t;
endpackage

// File: rtl/can_stamp_datapath.sv
module can_stamp_datapath
  import can_stamp_pkg::*;
#(
  parameter int CYC_W     = 4,
  parameter int CMP_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       ctl,
  input  logic             tickEn,
  input  logic             forceLoad,
  input  logic [TS_W-1:0]  forceValue,
  input  logic [CYC_W-1:0] cycleCount,
  input  logic             rxd,
  input  logic             sleepMode,
  output logic [TS_W-1:0]  cntQ,
  output logic [TS_W-1:0]  offQ,
  output logic [TS_W-1:0]  cmpQ,
  output evtStrobe_t       evt
);
  localparam logic [TS_W-1:0] ALL_ONES = {TS_W{1'b1}};
  localparam int SYNC_N = 2;

  logic            atTop;
  logic [TS_W-1:0] cmpTarget;
  logic            cmpEqual;
  logic            cmpEqualPrev;
  logic [SYNC_N-1:0] rxChain;
  logic            rxSync;
  logic            rxPrev;

  assign atTop = (cntQ == ALL_ONES);

  // timestamp counter: force beats register write beats tick
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (forceLoad) begin
      cntQ <= forceValue;
    end else if (ctl.cntWr) begin
      cntQ <= ctl.wrData;
    end else if (tickEn) begin
      cntQ <= atTop ? offQ : cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offQ <= '0;
      cmpQ <= '0;
    end else begin
      if (ctl.offWr) offQ <= ctl.wrData;
      if (ctl.cmpWr) cmpQ <= ctl.wrData;
    end
  end

  assign evt.ovfEv = (forceLoad && (forceValue == ALL_ONES)) ||
                     (!forceLoad && !ctl.cntWr && tickEn && atTop);

  // compare target selection
  assign cmpTarget = ctl.cmpMode
                   ? (cntQ >> CMP_SHIFT) + {{(TS_W-CYC_W){1'b0}}, cycleCount}
                   : cntQ;
  assign cmpEqual  = (cmpQ != '0) && (cmpTarget == cmpQ);

  always_ff @(posedge clk) begin
    if (!rst_n) cmpEqualPrev <= 1'b0;
    else        cmpEqualPrev <= cmpEqual;
  end

  assign evt.cmpEv = cmpEqual && !cmpEqualPrev;

  // receive line synchronizer, idle level is recessive (1)
  generate
    for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rst_n) rxChain[i] <= 1'b1;
        else        rxChain[i] <= (i == 0) ? rxd : rxChain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign rxSync = rxChain[SYNC_N-1];

  always_ff @(posedge clk) begin
    if (!rst_n) rxPrev <= 1'b1;
    else        rxPrev <= rxSync;
  end

  assign evt.wakeEv = sleepMode && rxPrev && !rxSync;
endmodule

// File: rtl/can_stamp_control.sv
module can_stamp_control
  import can_stamp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [TS_W-1:0]    wrData,
  input  logic               autoWake,
  input  evtStrobe_t         evt,
  input  logic [TS_W-1:0]    cntQ,
  input  logic [TS_W-1:0]    offQ,
  input  logic [TS_W-1:0]    cmpQ,
  output ctlStrobe_t         ctl,
  output logic [N_FLAGS-1:0] flagQ,
  output logic [TS_W-1:0]    rdData,
  output logic               irq,
  output logic               wakeReq
);
  logic               modeQ;
  logic [N_FLAGS-1:0] ieQ;
  logic [N_FLAGS-1:0] evVec;
  logic [N_FLAGS-1:0] clrVec;
  logic               ctrlWr;

  assign ctl.cntWr   = wrEn && (addr == A_CNT);
  assign ctl.offWr   = wrEn && (addr == A_OFF);
  assign ctl.cmpWr   = wrEn && (addr == A_CMP);
  assign ctl.cmpMode = modeQ;
  assign ctl.wrData  = wrData;
  assign ctrlWr      = wrEn && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ <= 1'b0;
      ieQ   <= '0;
    end else if (ctrlWr) begin
      modeQ <= wrData[0];
      ieQ   <= wrData[IE_LSB +: N_FLAGS];
    end
  end

  always_comb begin
    evVec         = '0;
    evVec[F_OVF]  = evt.ovfEv;
    evVec[F_WAKE] = evt.wakeEv;
    evVec[F_CMP]  = evt.cmpEv;
  end

  assign clrVec = (wrEn && (addr == A_FLAG)) ? wrData[N_FLAGS-1:0] : '0;

  // sticky flags: a hardware set outranks a software clear
  generate
    for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rst_n)        flagQ[f] <= 1'b0;
        else if (evVec[f]) flagQ[f] <= 1'b1;
        else if (clrVec[f]) flagQ[f] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) wakeReq <= 1'b0;
    else        wakeReq <= evt.wakeEv && autoWake;
  end

  assign irq = |(flagQ & ieQ);

  always_comb begin
    rdData = '0;
    case (addr)
      A_CNT:  rdData = cntQ;
      A_OFF:  rdData = offQ;
      A_CMP:  rdData = cmpQ;
      A_CTRL: begin
        rdData[0]                  = modeQ;
        rdData[IE_LSB +: N_FLAGS]  = ieQ;
      end
      A_FLAG: rdData[N_FLAGS-1:0] = flagQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/can_stamp_timer.sv
module can_stamp_timer
  import can_stamp_pkg::*;
#(
  parameter int CYC_W     = 4,
  parameter int CMP_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             forceLoad,
  input  logic [15:0]      forceValue,
  input  logic [CYC_W-1:0] cycleCount,
  input  logic             rxd,
  input  logic             sleepMode,
  input  logic             autoWake,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  output logic             irq,
  output logic             wakeReq
);
  ctlStrobe_t         ctl;
  evtStrobe_t         evt;
  logic [TS_W-1:0]    cntQ;
  logic [TS_W-1:0]    offQ;
  logic [TS_W-1:0]    cmpQ;
  logic [N_FLAGS-1:0] flagQ;

  can_stamp_datapath #(.CYC_W(CYC_W), .CMP_SHIFT(CMP_SHIFT)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .tickEn(tickEn),
    .forceLoad(forceLoad), .forceValue(forceValue), .cycleCount(cycleCount),
    .rxd(rxd), .sleepMode(sleepMode),
    .cntQ(cntQ), .offQ(offQ), .cmpQ(cmpQ), .evt(evt)
  );

  can_stamp_control u_ctl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .autoWake(autoWake), .evt(evt), .cntQ(cntQ), .offQ(offQ), .cmpQ(cmpQ),
    .ctl(ctl), .flagQ(flagQ), .rdData(rdData), .irq(irq), .wakeReq(wakeReq)
  );
endmodule

// File: rtl/can_stamp_timer_chk.sv
module can_stamp_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tickEn,
  input logic        forceLoad,
  input logic [15:0] forceValue,
  input logic        wrEn,
  input logic [2:0]  addr,
  input logic [2:0]  wrBits,
  input logic [15:0] cntQ,
  input logic [15:0] offQ,
  input logic [15:0] cmpQ,
  input logic [2:0]  flagQ,
  input logic [2:0]  evVec,
  input logic        sleepMode,
  input logic        irq,
  input logic        wakeReq
);
  assert_wrap_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && !forceLoad && !(wrEn && addr == 3'd0) && cntQ == 16'hFFFF)
    |=> (cntQ == $past(offQ)) && flagQ[0]);

  assert_force_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (forceLoad && forceValue == 16'hFFFF) |=> flagQ[0]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == 3'd4)
    |=> ((flagQ & $past(wrBits) & ~$past(evVec)) == 3'b000));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evVec != 3'b000) |=> ((flagQ & $past(evVec)) == $past(evVec)));

  assert_no_zero_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagQ[2]) |-> ($past(cmpQ) != 16'h0000));

  assert_wake_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagQ[1]) |-> $past(sleepMode));

  assert_wake_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wakeReq |-> flagQ[1]);

  assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flagQ != 3'b000));
endmodule

bind can_stamp_timer can_stamp_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .forceLoad(forceLoad),
  .forceValue(forceValue), .wrEn(wrEn), .addr(addr), .wrBits(wrData[2:0]),
  .cntQ(cntQ), .offQ(offQ), .cmpQ(cmpQ), .flagQ(flagQ),
  .evVec({evt.cmpEv, evt.wakeEv, evt.ovfEv}),
  .sleepMode(sleepMode), .irq(irq), .wakeReq(wakeReq)
);

// File: tb/can_stamp_timer_bench.sv
module can_stamp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        forceLoad = 1'b0;
  logic [15:0] forceValue = '0;
  logic [3:0]  cycleCount = '0;
  logic        rxd = 1'b1;
  logic        sleepMode = 1'b0;
  logic        autoWake = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;
  logic        wakeReq;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  can_stamp_timer u_can_stamp_timer (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .forceLoad(forceLoad),
    .forceValue(forceValue), .cycleCount(cycleCount), .rxd(rxd),
    .sleepMode(sleepMode), .autoWake(autoWake), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wakeReq(wakeReq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic clearFlags();
    regWrite(3'd4, 16'h0007);
  endtask

  task automatic testReset();
    logic [15:0] v;
    for (int a = 0; a < 5; a++) begin
      regRead(3'(a), v);
      check("R1 reset register", v, 16'h0000);
    end
    check("R1 reset irq", {15'd0, irq}, 16'd0);
    check("R1 reset wakeReq", {15'd0, wakeReq}, 16'd0);
    tickEn = 1'b1;
    repeat (5) @(negedge clk);
    tickEn = 1'b0;
    regRead(3'd0, v);
    check("R1 increment", v, 16'd5);
  endtask

  task automatic testRegs();
    logic [15:0] v;
    regWrite(3'd1, 16'hBEEF);
    regWrite(3'd2, 16'h0ABC);
    regWrite(3'd3, 16'h0501);
    regRead(3'd1, v); check("R12 offset read", v, 16'hBEEF);
    regRead(3'd2, v); check("R12 compare read", v, 16'h0ABC);
    regRead(3'd3, v); check("R12 control read", v, 16'h0501);
    regWrite(3'd3, 16'h0000);
    regWrite(3'd2, 16'h0000);
  endtask

  task automatic testWrap();
    logic [15:0] v;
    clearFlags();
    regWrite(3'd1, 16'h1234);
    regWrite(3'd0, 16'hFFFD);
    tickEn = 1'b1;
    repeat (2) @(negedge clk);
    regRead(3'd4, v); check("R2 no overrun before top", v, 16'h0000);
    @(negedge clk);
    tickEn = 1'b0;
    regRead(3'd0, v); check("R2 reload from offset", v, 16'h1234);
    regRead(3'd4, v); check("R2 overrun flag", v, 16'h0001);
  endtask

  task automatic testForce();
    logic [15:0] v;
    clearFlags();
    forceLoad = 1'b1; forceValue = 16'h5555;
    @(negedge clk);
    forceLoad = 1'b0;
    regRead(3'd0, v); check("R3 force value", v, 16'h5555);
    regRead(3'd4, v); check("R3 no flag other value", v, 16'h0000);
    forceLoad = 1'b1; forceValue = 16'hFFFF;
    @(negedge clk);
    forceLoad = 1'b0;
    regRead(3'd0, v); check("R3 force top", v, 16'hFFFF);
    regRead(3'd4, v); check("R3 flag on top", v, 16'h0001);
  endtask

  task automatic testClear();
    logic [15:0] v;
    // overrun flag is set from testForce
    regWrite(3'd4, 16'h0006);
    regRead(3'd4, v); check("R4 write zero keeps flag", v, 16'h0001);
    regWrite(3'd4, 16'h0001);
    regRead(3'd4, v); check("R4 write one clears", v, 16'h0000);
  endtask

  task automatic testCmpMode0();
    logic [15:0] v;
    clearFlags();
    regWrite(3'd0, 16'h0010);
    regWrite(3'd2, 16'h0012);
    tickEn = 1'b1;
    repeat (2) @(negedge clk);
    tickEn = 1'b0;
    regRead(3'd4, v); check("R6 not yet set", v, 16'h0000);
    @(negedge clk);
    regRead(3'd4, v); check("R6 match flag", v, 16'h0004);
    regWrite(3'd4, 16'h0004);
    repeat (3) @(negedge clk);
    regRead(3'd4, v); check("R6 no retrigger when stalled", v, 16'h0000);
  endtask

  task automatic testCmpMode1();
    logic [15:0] v;
    clearFlags();
    cycleCount = 4'd3;
    regWrite(3'd0, 16'h0120);
    regWrite(3'd2, 16'h0015);
    regRead(3'd4, v); check("R7 no raw match", v, 16'h0000);
    regWrite(3'd3, 16'h0001);
    @(negedge clk);
    regRead(3'd4, v); check("R7 cycle plus upper bits match", v, 16'h0004);
    regWrite(3'd3, 16'h0000);
    cycleCount = 4'd0;
  endtask

  task automatic testCmpZero();
    logic [15:0] v;
    regWrite(3'd2, 16'h0000);
    regWrite(3'd0, 16'h0000);
    clearFlags();
    regWrite(3'd3, 16'h0001);
    repeat (2) @(negedge clk);
    regWrite(3'd3, 16'h0000);
    tickEn = 1'b1;
    repeat (4) @(negedge clk);
    tickEn = 1'b0;
    @(negedge clk);
    regRead(3'd4, v); check("R8 zero compare never matches", v, 16'h0000);
  endtask

  task automatic testWake();
    logic [15:0] v;
    clearFlags();
    sleepMode = 1'b1; autoWake = 1'b1;
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    regRead(3'd4, v); check("R9 not yet through sync", v, 16'h0000);
    @(negedge clk);
    regRead(3'd4, v); check("R9 wake flag", v, 16'h0002);
    check("R10 wake request", {15'd0, wakeReq}, 16'd1);
    @(negedge clk);
    check("R10 wake request one cycle", {15'd0, wakeReq}, 16'd0);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    clearFlags();
    sleepMode = 1'b0;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    regRead(3'd4, v); check("R9 awake edge ignored", v, 16'h0000);
    check("R10 no request when awake", {15'd0, wakeReq}, 16'd0);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic testSetWins();
    logic [15:0] v;
    clearFlags();
    sleepMode = 1'b1; autoWake = 1'b0;
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    regWrite(3'd4, 16'h0002);
    regRead(3'd4, v); check("R5 set beats clear", v, 16'h0002);
    rxd = 1'b1; sleepMode = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testIrq();
    logic [15:0] v;
    clearFlags();
    regWrite(3'd3, 16'h0000);
    forceLoad = 1'b1; forceValue = 16'hFFFF;
    @(negedge clk);
    forceLoad = 1'b0;
    regRead(3'd4, v); check("R11 overrun set", v, 16'h0001);
    check("R11 masked", {15'd0, irq}, 16'd0);
    regWrite(3'd3, 16'h0100);
    check("R11 enabled", {15'd0, irq}, 16'd1);
    regWrite(3'd3, 16'h0600);
    check("R11 other enables only", {15'd0, irq}, 16'd0);
    regWrite(3'd3, 16'h0700);
    clearFlags();
    check("R11 cleared", {15'd0, irq}, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testWrap();
    testForce();
    testClear();
    testCmpMode0();
    testCmpMode1();
    testCmpZero();
    testWake();
    testSetWins();
    testIrq();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule